// File: doc/BRIEF.md
# Windowed Configuration Stream Loader

This block takes in a configuration download one byte at a time and steps through a fixed layout of fields. Bytes arrive either on a parallel byte port or as single bits on a serial input, which are packed into bytes most significant bit first. A download can begin only from idle, and only when the configuration enable and at least one of the two chip selects are high together.

Each download has a fixed set of fields. It opens with a filler byte and a preamble byte. These are followed by a four-byte control word and a sixteen-bit window count. For each window there is a start address, an end address and one data byte per address. A closing postamble byte ends the stream. For every data byte the loader writes one word to a configuration memory port. When the CHECK bit of the control word is set, it instead compares the byte with what the memory returns at that address.

A malformed stream pulls the active-low `init_n` output low and stops the download. This happens on a wrong preamble, an illegal window, a verify mismatch or a wrong postamble. A clean finish pulses `done` and returns the loader to idle.

Top module: `cfgld_top`

## Requirements
- R1: After reset, `init_n` is 1, `done` is 0, `mem_we` is 0 and `ctrl_word` is 0.
- R2: A download starts only when `cfg_en` is 1 and `csel_a` or `csel_b` is 1 while the loader is idle. Bytes sent without that start are ignored: no memory write, no `done`, and `init_n` stays 1.
- R3: With `ser_mode` = 0, each cycle with `byte_valid` = 1 delivers `byte_in`. With `ser_mode` = 1, each cycle with `ser_valid` = 1 shifts in `ser_bit`, and every eight bits form one byte, the first bit becoming bit 7.
- R4: The first byte of a download is discarded whatever its value. The second byte must be 0xB7. Any other value drives `init_n` to 0, and no memory write follows.
- R5: The next four bytes fill `ctrl_word`, the first into bits 7:0 and the fourth into bits 31:24. CHECK is `ctrl_word[0]`.
- R6: The next two bytes form the window count, high byte first. A count of zero skips directly to the postamble.
- R7: Each window sends a 3-byte start address, then a 3-byte end address, high byte first in both. If start > end or end > `MAX_ADDR`, `init_n` goes to 0 and no data of that window is written.
- R8: With CHECK = 0, the data bytes of a window are written in order, one per cycle of `mem_we`, to addresses start through end (`mem_addr`, `mem_wdata`). After the last byte the next window begins, or the postamble after the last window.
- R9: With CHECK = 1, no write is issued. Each data byte is compared with `mem_rdata` read at `mem_addr`, and a mismatch drives `init_n` to 0.
- R10: A postamble of 0xE7 gives a one-cycle `done` pulse and returns the loader to idle. Any other value drives `init_n` to 0.
- R11: Once `init_n` is 0, it stays 0 and the loader ignores input while `cfg_en` stays 1. After `cfg_en` falls, the loader returns to idle with `init_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration enable |
| csel_a | input | 1 | Chip select, first |
| csel_b | input | 1 | Chip select, second |
| ser_mode | input | 1 | 1: serial bit input, 0: parallel byte input |
| ser_bit | input | 1 | Serial data bit |
| ser_valid | input | 1 | Serial bit strobe |
| byte_in | input | 8 | Parallel data byte |
| byte_valid | input | 1 | Parallel byte strobe |
| mem_rdata | input | 8 | Memory read data at `mem_addr` (combinational read) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| init_n | output | 1 | Active-low error flag |
| done | output | 1 | One-cycle pulse on a clean finish |
| ctrl_word | output | 32 | Loaded control word |

## Verification
The bench builds the loader with `ADDR_W` = 6 and `MAX_ADDR` = 40. This keeps the memory model small enough to mirror in full. It also puts the top legal address inside a short stream, so a window that ends exactly at the limit can be written, while a window ending one address beyond it is rejected. The verify mode is exercised against the bench's own copy of memory contents laid down by an earlier write download, both with matching data and with deliberately different data.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 24;
    localparam int CTRL_W  = 32;
    localparam int CNT_W   = 16;
    localparam int BITC_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] PREAMBLE  = 8'hB7;
    localparam logic [BYTE_W-1:0] POSTAMBLE = 8'hE7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NULL,
        ST_PRE,
        ST_CTRL,
        ST_CNT,
        ST_SADR,
        ST_EADR,
        ST_DATA,
        ST_POST,
        ST_ERR
    } ld_state_e;

    typedef struct packed {
        ld_state_e          st;
        logic [1:0]         idx;
        logic [CTRL_W-1:0]  ctrl;
        logic [CNT_W-1:0]   wleft;
        logic [FIELD_W-1:0] sadr;
        logic [FIELD_W-1:0] eadr;
        logic [FIELD_W-1:0] cur;
        logic               done;
    } ld_regs_t;

    typedef struct packed {
        logic [BYTE_W-1:0] shift;
        logic [BITC_W-1:0] cnt;
        logic [BYTE_W-1:0] data;
        logic              vld;
    } des_regs_t;

endpackage

// File: rtl/cfgld_deser.sv
module cfgld_deser
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen,
    input  logic              ser_mode,
    input  logic              ser_bit,
    input  logic              ser_valid,
    input  logic [BYTE_W-1:0] par_byte,
    input  logic              par_valid,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o
);

    localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(BYTE_W - 1);

    des_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (!listen) begin
            r_d.cnt   = '0;
            r_d.shift = '0;
        end else if (ser_mode) begin
            if (ser_valid) begin
                r_d.shift = {r_q.shift[BYTE_W-2:0], ser_bit};
                if (r_q.cnt == LAST_BIT) begin
                    r_d.cnt  = '0;
                    r_d.data = {r_q.shift[BYTE_W-2:0], ser_bit};
                    r_d.vld  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end else if (par_valid) begin
            r_d.data = par_byte;
            r_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign byte_o  = r_q.data;
    assign valid_o = r_q.vld;

endmodule

// File: rtl/cfgld_win_check.sv
module cfgld_win_check
    import cfgld_pkg::*;
#(
    parameter logic [FIELD_W-1:0] MAX_ADDR = 24'h000FFF
) (
    input  logic [FIELD_W-1:0] start_adr,
    input  logic [FIELD_W-1:0] end_adr,
    output logic               legal
);

    logic ordered;
    logic in_array;

    always_comb begin
        ordered  = (start_adr <= end_adr);
        in_array = (end_adr <= MAX_ADDR);
        legal    = ordered && in_array;
    end

endmodule

// File: rtl/cfgld_parser.sv
module cfgld_parser
    import cfgld_pkg::*;
#(
    parameter int                 ADDR_W   = 12,
    parameter logic [FIELD_W-1:0] MAX_ADDR = 24'h000FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              start_sel,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              listen,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              init_n,
    output logic              done,
    output logic [CTRL_W-1:0] ctrl_word
);

    localparam logic [1:0] CTRL_LAST = 2'd3;
    localparam logic [1:0] CNT_LAST  = 2'd1;
    localparam logic [1:0] ADR_LAST  = 2'd2;

    ld_regs_t q, d;

    logic [FIELD_W-1:0] end_next;
    logic [CNT_W-1:0]   cnt_next;
    logic               win_legal;
    logic               check_on;
    logic               take;

    assign check_on = q.ctrl[0];
    assign end_next = {q.eadr[FIELD_W-BYTE_W-1:0], in_byte};
    assign cnt_next = {q.wleft[CNT_W-BYTE_W-1:0], in_byte};

    cfgld_win_check #(
        .MAX_ADDR(MAX_ADDR)
    ) i_win_check (
        .start_adr(q.sadr),
        .end_adr  (end_next),
        .legal    (win_legal)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        take   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cfg_en && start_sel) begin
                    d.st  = ST_NULL;
                    d.idx = '0;
                end
            end
            ST_NULL: begin
                if (in_valid) d.st = ST_PRE;
            end
            ST_PRE: begin
                if (in_valid) begin
                    d.st  = (in_byte == PREAMBLE) ? ST_CTRL : ST_ERR;
                    d.idx = '0;
                end
            end
            ST_CTRL: begin
                if (in_valid) begin
                    d.ctrl[{q.idx, 3'b000} +: BYTE_W] = in_byte;
                    if (q.idx == CTRL_LAST) begin
                        d.idx = '0;
                        d.st  = ST_CNT;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_CNT: begin
                if (in_valid) begin
                    d.wleft = cnt_next;
                    if (q.idx == CNT_LAST) begin
                        d.idx = '0;
                        d.st  = (cnt_next == '0) ? ST_POST : ST_SADR;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_SADR: begin
                if (in_valid) begin
                    d.sadr = {q.sadr[FIELD_W-BYTE_W-1:0], in_byte};
                    if (q.idx == ADR_LAST) begin
                        d.idx = '0;
                        d.st  = ST_EADR;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_EADR: begin
                if (in_valid) begin
                    d.eadr = end_next;
                    if (q.idx == ADR_LAST) begin
                        d.idx = '0;
                        d.cur = q.sadr;
                        d.st  = win_legal ? ST_DATA : ST_ERR;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (in_valid) begin
                    take = 1'b1;
                    if (check_on && (in_byte != mem_rdata)) begin
                        d.st = ST_ERR;
                    end else if (q.cur == q.eadr) begin
                        d.wleft = q.wleft - 1'b1;
                        d.st    = (q.wleft == 16'd1) ? ST_POST : ST_SADR;
                    end else begin
                        d.cur = q.cur + 1'b1;
                    end
                end
            end
            ST_POST: begin
                if (in_valid) begin
                    if (in_byte == POSTAMBLE) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_ERR;
                    end
                end
            end
            ST_ERR: begin
                if (!cfg_en) d.st = ST_IDLE;
            end
            default: d.st = ST_ERR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign listen    = (q.st != ST_IDLE) && (q.st != ST_ERR);
    assign mem_we    = take && !check_on;
    assign mem_addr  = q.cur[ADDR_W-1:0];
    assign mem_wdata = in_byte;
    assign init_n    = (q.st != ST_ERR);
    assign done      = q.done;
    assign ctrl_word = q.ctrl;

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int                 ADDR_W   = 12,
    parameter logic [FIELD_W-1:0] MAX_ADDR = 24'h000FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              csel_a,
    input  logic              csel_b,
    input  logic              ser_mode,
    input  logic              ser_bit,
    input  logic              ser_valid,
    input  logic [7:0]        byte_in,
    input  logic              byte_valid,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              init_n,
    output logic              done,
    output logic [31:0]       ctrl_word
);

    logic              listen;
    logic [BYTE_W-1:0] des_byte;
    logic              des_valid;
    logic              start_sel;

    assign start_sel = csel_a || csel_b;

    cfgld_deser i_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .listen   (listen),
        .ser_mode (ser_mode),
        .ser_bit  (ser_bit),
        .ser_valid(ser_valid),
        .par_byte (byte_in),
        .par_valid(byte_valid),
        .byte_o   (des_byte),
        .valid_o  (des_valid)
    );

    cfgld_parser #(
        .ADDR_W  (ADDR_W),
        .MAX_ADDR(MAX_ADDR)
    ) i_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .start_sel(start_sel),
        .in_byte  (des_byte),
        .in_valid (des_valid),
        .mem_rdata(mem_rdata),
        .listen   (listen),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .init_n   (init_n),
        .done     (done),
        .ctrl_word(ctrl_word)
    );

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int          ADDR_W   = 12,
    parameter logic [23:0] MAX_ADDR = 24'h000FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_n,
    input logic              done,
    input logic [31:0]       ctrl_word
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> init_n);

    a_r11_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && cfg_en) |=> !init_n);

    a_r11_no_write_in_error: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> !mem_we);

    a_r9_verify_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ctrl_word[0]);

    a_r7_write_within_array: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (24'(mem_addr) <= MAX_ADDR));

endmodule

bind cfgld_top cfgld_checker #(
    .ADDR_W  (ADDR_W),
    .MAX_ADDR(MAX_ADDR)
) i_cfgld_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .init_n   (init_n),
    .done     (done),
    .ctrl_word(ctrl_word)
);

// File: tb/test_cfgld_top.sv
`timescale 1ns/1ps
module test_cfgld_top;

    localparam int          ADDR_W   = 6;
    localparam logic [23:0] MAX_ADDR = 24'd40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_en = 1'b0, csel_a = 1'b0, csel_b = 1'b0;
    logic              ser_mode = 1'b0, ser_bit = 1'b0, ser_valid = 1'b0;
    logic [7:0]        byte_in = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        mem_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              init_n;
    logic              done;
    logic [31:0]       ctrl_word;

    logic [7:0] mem_model [0:(1<<ADDR_W)-1];
    logic [31:0] exp_q [$];
    int total = 0, bad = 0, done_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfgld_top #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) i_cfgld_top (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .csel_a(csel_a), .csel_b(csel_b),
        .ser_mode(ser_mode), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .byte_in(byte_in), .byte_valid(byte_valid), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .init_n(init_n), .done(done), .ctrl_word(ctrl_word)
    );

    assign mem_rdata = mem_model[mem_addr];

    initial for (int i = 0; i < (1<<ADDR_W); i++) mem_model[i] = 8'h00;

    always @(posedge clk) if (mem_we) mem_model[mem_addr] <= mem_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes as the design issues them
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R9 unexpected write", {18'(mem_addr), 6'd0, mem_wdata}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check({24'(mem_addr), mem_wdata} == e, "R8 write addr/data",
                          {24'(mem_addr), mem_wdata}, e);
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        if (ser_mode) begin
            for (int i = 7; i >= 0; i--) begin
                @(negedge clk); ser_bit = b[i]; ser_valid = 1'b1;
            end
            @(negedge clk); ser_valid = 1'b0;
        end else begin
            @(negedge clk); byte_in = b; byte_valid = 1'b1;
            @(negedge clk); byte_valid = 1'b0;
        end
    endtask

    task automatic send3(input logic [23:0] v);
        send_byte(v[23:16]); send_byte(v[15:8]); send_byte(v[7:0]);
    endtask

    task automatic begin_dl(input bit a, input bit b);
        @(negedge clk); cfg_en = 1'b1; csel_a = a; csel_b = b;
        @(negedge clk); csel_a = 1'b0; csel_b = 1'b0;
    endtask

    task automatic end_dl();
        @(negedge clk); cfg_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic header(input logic [7:0] nullb, input logic [7:0] pre,
                          input logic [31:0] ctrl, input logic [15:0] cnt);
        send_byte(nullb); send_byte(pre);
        send_byte(ctrl[7:0]); send_byte(ctrl[15:8]); send_byte(ctrl[23:16]); send_byte(ctrl[31:24]);
        send_byte(cnt[15:8]); send_byte(cnt[7:0]);
    endtask

    task automatic send_window(input logic [23:0] s, input logic [23:0] e,
                               input logic [7:0] seed, input bit wr);
        send3(s); send3(e);
        for (int a = int'(s); a <= int'(e); a++) begin
            logic [7:0] dv;
            dv = 8'(a * 7) + seed;
            if (wr) exp_q.push_back({24'(a), dv});
            send_byte(dv);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(init_n == 1'b1, "R1 init_n", 32'(init_n), 1);
        check(done == 1'b0 && mem_we == 1'b0, "R1 done/we", {30'd0, done, mem_we}, 0);
        check(ctrl_word == 32'h0, "R1 ctrl_word", ctrl_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 R5 R10: parallel write download, two windows
        d0 = done_cnt;
        begin_dl(1, 0);
        header(8'h00, 8'hB7, 32'h5A3C1200, 16'd2);
        send_window(24'd2, 24'd5, 8'd1, 1);
        send_window(24'd10, 24'd10, 8'd1, 1);
        send_byte(8'hE7);
        settle();
        check(ctrl_word == 32'h5A3C1200, "R5 control word order", ctrl_word, 32'h5A3C1200);
        check(exp_q.size() == 0, "R8 all writes issued", exp_q.size(), 0);
        check(done_cnt == d0 + 1, "R10 done pulse", done_cnt - d0, 1);
        check(init_n == 1'b1, "R10 no error", 32'(init_n), 1);
        end_dl();

        // R3: serial download with second select, window ending at MAX_ADDR
        ser_mode = 1'b1;
        d0 = done_cnt;
        begin_dl(0, 1);
        header(8'h00, 8'hB7, 32'h00000000, 16'd2);
        send_window(24'd20, 24'd23, 8'd3, 1);
        send_window(24'd40, 24'd40, 8'd3, 1);
        send_byte(8'hE7);
        settle();
        check(exp_q.size() == 0, "R3 serial writes", exp_q.size(), 0);
        check(done_cnt == d0 + 1, "R3 serial done", done_cnt - d0, 1);
        end_dl();
        ser_mode = 1'b0;

        // R9: verify mode with matching data
        d0 = done_cnt;
        begin_dl(1, 0);
        header(8'h00, 8'hB7, 32'h00000001, 16'd1);
        send_window(24'd2, 24'd5, 8'd1, 0);
        send_byte(8'hE7);
        settle();
        check(ctrl_word[0] == 1'b1, "R5 CHECK bit", ctrl_word, 1);
        check(done_cnt == d0 + 1 && init_n, "R9 verify pass", done_cnt - d0, 1);
        end_dl();

        // R9 R11: verify mismatch, then recovery
        begin_dl(1, 0);
        header(8'h00, 8'hB7, 32'h00000001, 16'd1);
        send_window(24'd2, 24'd5, 8'd9, 0);
        settle();
        check(init_n == 1'b0, "R9 mismatch error", 32'(init_n), 0);
        end_dl();
        check(init_n == 1'b1, "R11 recovery", 32'(init_n), 1);

        // R4 R11: bad preamble, error held while enabled
        d0 = done_cnt;
        begin_dl(1, 0);
        send_byte(8'h00); send_byte(8'hB6);
        settle();
        check(init_n == 1'b0, "R4 bad preamble", 32'(init_n), 0);
        header(8'h00, 8'hB7, 32'h0, 16'd1);
        send_window(24'd30, 24'd30, 8'd5, 0);
        send_byte(8'hE7);
        settle();
        check(init_n == 1'b0 && done_cnt == d0, "R11 error sticky", 32'(init_n), 0);
        end_dl();

        // R4: nonzero filler byte is accepted; R6: zero window count
        d0 = done_cnt;
        begin_dl(1, 0);
        header(8'h5C, 8'hB7, 32'h0, 16'd0);
        send_byte(8'hE7);
        settle();
        check(done_cnt == d0 + 1 && init_n, "R4/R6 filler and empty count", done_cnt - d0, 1);
        end_dl();

        // R7: start above end
        begin_dl(1, 0);
        header(8'h00, 8'hB7, 32'h0, 16'd1);
        send3(24'd7); send3(24'd6);
        settle();
        check(init_n == 1'b0, "R7 start>end", 32'(init_n), 0);
        end_dl();

        // R7: end beyond array
        begin_dl(1, 0);
        header(8'h00, 8'hB7, 32'h0, 16'd1);
        send3(24'd39); send3(24'd41);
        settle();
        check(init_n == 1'b0, "R7 end>MAX_ADDR", 32'(init_n), 0);
        end_dl();

        // R10: wrong postamble
        d0 = done_cnt;
        begin_dl(1, 0);
        header(8'h00, 8'hB7, 32'h0, 16'd1);
        send_window(24'd12, 24'd13, 8'd2, 1);
        send_byte(8'hE6);
        settle();
        check(init_n == 1'b0 && done_cnt == d0, "R10 bad postamble", 32'(init_n), 0);
        check(exp_q.size() == 0, "R8 writes before bad postamble", exp_q.size(), 0);
        end_dl();

        // R2: enable without chip select is ignored
        d0 = done_cnt;
        @(negedge clk); cfg_en = 1'b1;
        header(8'h00, 8'hB7, 32'h0, 16'd1);
        send_window(24'd33, 24'd33, 8'd4, 0);
        send_byte(8'hE7);
        settle();
        check(done_cnt == d0 && init_n, "R2 no select ignored", done_cnt - d0, 0);
        check(mem_model[33] == 8'h00, "R2 memory untouched", mem_model[33], 0);
        end_dl();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule